// File: doc/BRIEF.md
# Boot ROM Overlay Memory Decoder

This decoder produces the chip selects for a coprocessor board that carries 64K of RAM and a small boot ROM. After reset the ROM shadows the upper half of the address map for reads. The CPU can then start from its reset vector and copy what it needs into RAM. Writes are never blocked by the overlay. A program can therefore fill the RAM underneath the ROM while it is still running out of the ROM image.

A one-bit overlay flag decides whether upper-half reads go to ROM or to RAM. Reset sets the flag. The flag is cleared as a side effect of the first valid access, read or write, to an eight-byte window that holds the host-interface registers. From that point on, the full 64K address space is RAM until the next reset.

The ROM device is 2K and is wired to the top of the map at 0xF800. While the overlay is active, the decoder enables it for every upper-half read, so the image repeats across the whole 32K. Each valid bus cycle selects exactly one target, and all selects are active-high.

Top module: `boot_overlay_decoder`

## Requirements
- R1: After a synchronous active-high reset, the overlay is on: a valid read at 0x8000 asserts `rom_oe` only.
- R2: While the overlay is on, a valid read with address bit 15 set (not in the window) asserts `rom_oe` and leaves `ram_sel` low. This includes the ROM base 0xF800 and the top address 0xFFFF.
- R3: A valid read with address bit 15 clear asserts `ram_sel` only, whether the overlay is on or off.
- R4: A valid write outside the window asserts `ram_sel` only, including upper-half writes while the overlay is on.
- R5: `win_sel` is asserted for valid accesses to 0xFEF8 through 0xFEFF, and for no other address. 0xFEF7 and 0xFF00 are not window addresses. A window access asserts neither `ram_sel` nor `rom_oe`.
- R6: A valid window access, read or write, turns the overlay off at the clock edge that ends that access. Cycles up to and including the window access still see the overlay on. Later upper-half reads assert `ram_sel` until the next reset.
- R7: When `cyc_vld` is low, all three selects are low. When `cyc_vld` is high, exactly one select is high.
- R8: The overlay changes only on reset or on a valid window access. A window address presented with `cyc_vld` low leaves the overlay on.
- R9: Reset applied after the overlay has been turned off turns it back on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active-high |
| addr | input | 16 | CPU address bus |
| rd_nwr | input | 1 | 1 = read cycle, 0 = write cycle |
| cyc_vld | input | 1 | High while the bus cycle is valid |
| ram_sel | output | 1 | RAM chip select, active-high |
| rom_oe | output | 1 | ROM output enable, active-high |
| win_sel | output | 1 | Host-interface register window select, active-high |

## Verification
The bench probes both edges of the window, at 0xFEF7 and 0xFF00. A decoder with a window mask one bit too wide or too narrow would then select the interface on a neighbouring address, or miss one of its eight registers. It writes into the upper half while the overlay is on. A decoder that gated writes by the overlay would route those writes to the ROM and lose them. It presents a window address with the valid strobe low and expects the overlay to survive. A design that cleared the flag on the raw address would page the ROM out too early. It also checks that the overlay turns off exactly one cycle after the window access and that a second reset brings it back.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

    localparam int ADDR_W = 16;

    // one field per target; at most one is set in a valid cycle
    typedef struct packed {
        logic ram;
        logic rom;
        logic win;
    } sel_t;

    localparam sel_t SEL_NONE = '{ram: 1'b0, rom: 1'b0, win: 1'b0};

    // true when the address falls inside an aligned block of 2**lg bytes at base
    function automatic logic in_block(input logic [ADDR_W-1:0] a,
                                      input logic [ADDR_W-1:0] base,
                                      input int unsigned lg);
        return (a >> lg) == (base >> lg);
    endfunction

endpackage

// File: rtl/ovl_win_decode.sv
module ovl_win_decode
    import ovl_pkg::*;
#(
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'hFEF8,
    parameter int unsigned       WIN_LG   = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    always_comb hit = in_block(addr, WIN_BASE, WIN_LG);
endmodule

// File: rtl/ovl_flag.sv
module ovl_flag (
    input  logic clk,
    input  logic rst,
    input  logic clr_req,
    output logic ovl_on
);
    always_ff @(posedge clk) begin
        if (rst)
            ovl_on <= 1'b1;
        else if (clr_req)
            ovl_on <= 1'b0;
    end

    logic past_ok;
    always_ff @(posedge clk) past_ok <= 1'b1;

    // R6
    clr_takes_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(clr_req) && !$past(rst) |-> !ovl_on);

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok && !$past(rst) && !$past(clr_req) |-> $stable(ovl_on));

    // R1
    reset_sets_chk: assert property (@(posedge clk)
        past_ok && $past(rst) |-> ovl_on);
endmodule

// File: rtl/ovl_sel.sv
module ovl_sel
    import ovl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic upper,
    input  logic rd,
    input  logic vld,
    input  logic win_hit,
    input  logic ovl_on,
    output sel_t sel
);
    always_comb begin
        sel = SEL_NONE;
        if (vld) begin
            if (win_hit)
                sel.win = 1'b1;
            else if (rd && upper && ovl_on)
                sel.rom = 1'b1;
            else
                sel.ram = 1'b1;
        end
    end

    // R7
    one_target_chk: assert property (@(posedge clk) disable iff (rst)
        vld |-> $countones(sel) == 1);

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !vld |-> sel == SEL_NONE);

    // R4
    rom_only_read_chk: assert property (@(posedge clk) disable iff (rst)
        sel.rom |-> rd && upper && ovl_on);

    // R3
    low_read_ram_chk: assert property (@(posedge clk) disable iff (rst)
        vld && rd && !upper |-> sel.ram);
endmodule

// File: rtl/boot_overlay_decoder.sv
module boot_overlay_decoder
    import ovl_pkg::*;
#(
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'hFEF8,
    parameter int unsigned       WIN_LG   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_nwr,
    input  logic              cyc_vld,
    output logic              ram_sel,
    output logic              rom_oe,
    output logic              win_sel
);
    localparam int          MSB      = ADDR_W - 1;
    localparam int unsigned WIN_SIZE = 1 << WIN_LG;

    logic win_hit;
    logic ovl_on;
    sel_t sel;

    ovl_win_decode #(.WIN_BASE(WIN_BASE), .WIN_LG(WIN_LG)) u_win (
        .addr (addr),
        .hit  (win_hit)
    );

    ovl_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .clr_req (cyc_vld && win_hit),
        .ovl_on  (ovl_on)
    );

    ovl_sel u_sel (
        .clk     (clk),
        .rst     (rst),
        .upper   (addr[MSB]),
        .rd      (rd_nwr),
        .vld     (cyc_vld),
        .win_hit (win_hit),
        .ovl_on  (ovl_on),
        .sel     (sel)
    );

    assign ram_sel = sel.ram;
    assign rom_oe  = sel.rom;
    assign win_sel = sel.win;

    // R5
    win_range_chk: assert property (@(posedge clk) disable iff (rst)
        win_sel |-> addr >= WIN_BASE && {1'b0, addr} < {1'b0, WIN_BASE} + WIN_SIZE);

    // R5
    win_excl_chk: assert property (@(posedge clk) disable iff (rst)
        win_sel |-> !ram_sel && !rom_oe);
endmodule

// File: tb/sim_boot_overlay_decoder.sv
`timescale 1ns/1ps
module sim_boot_overlay_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] addr = '0;
    logic        rd_nwr = 1'b1;
    logic        cyc_vld = 1'b0;
    logic        ram_sel, rom_oe, win_sel;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    boot_overlay_decoder u0 (
        .clk(clk), .rst(rst), .addr(addr), .rd_nwr(rd_nwr), .cyc_vld(cyc_vld),
        .ram_sel(ram_sel), .rom_oe(rom_oe), .win_sel(win_sel)
    );

    // {addr, rd, vld, exp ram, exp rom, exp win}; one vector per cycle after reset
    localparam int NV = 13;
    localparam logic [20:0] VEC [NV] = '{
        {16'h8000, 1'b1, 1'b1, 3'b010},
        {16'hF800, 1'b1, 1'b1, 3'b010},
        {16'h1234, 1'b1, 1'b1, 3'b100},
        {16'h9000, 1'b0, 1'b1, 3'b100},
        {16'hFEF8, 1'b1, 1'b0, 3'b000},
        {16'hC000, 1'b1, 1'b1, 3'b010},
        {16'hFEF7, 1'b1, 1'b1, 3'b010},
        {16'hFF00, 1'b0, 1'b1, 3'b100},
        {16'hFEFF, 1'b0, 1'b1, 3'b001},
        {16'h8000, 1'b1, 1'b1, 3'b100},
        {16'hFFFF, 1'b1, 1'b1, 3'b100},
        {16'hFEF8, 1'b1, 1'b1, 3'b001},
        {16'h0000, 1'b1, 1'b1, 3'b100}
    };

    function automatic string req_of(input int i);
        case (i)
            0, 1, 5: return "R2";
            2, 12:   return "R3";
            3, 7:    return "R4";
            4:       return "R7";
            6, 11:   return "R5";
            8:       return "R6";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string req, input logic [2:0] exp);
        n_run++;
        if ({ram_sel, rom_oe, win_sel} !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h actual ram/rom/win=%b expected=%b",
                     req, addr, {ram_sel, rom_oe, win_sel}, exp);
        end
    endtask

    task automatic drive(input logic [15:0] a, input logic r, input logic v);
        @(negedge clk);
        addr = a; rd_nwr = r; cyc_vld = v;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cyc_vld = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        drive(16'h8000, 1'b1, 1'b1);
        check("R1", 3'b010);
        // R7: idle cycle
        drive(16'h8000, 1'b1, 1'b0);
        check("R7", 3'b000);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][20:5], VEC[i][4], VEC[i][3]);
            check(req_of(i), VEC[i][2:0]);
        end

        // R9: reset restores overlay after it was turned off
        do_reset();
        drive(16'hA000, 1'b1, 1'b1);
        check("R9", 3'b010);
        // R8: window address with strobe low keeps overlay
        drive(16'hFEFC, 1'b0, 1'b0);
        check("R8", 3'b000);
        drive(16'hF800, 1'b1, 1'b1);
        check("R8", 3'b010);
        // R6: window read clears; the next cycle already sees RAM
        drive(16'hFEFA, 1'b1, 1'b1);
        check("R6", 3'b001);
        drive(16'hF800, 1'b1, 1'b1);
        check("R6", 3'b100);
        // R3: low read after clear still RAM
        drive(16'h7FFF, 1'b1, 1'b1);
        check("R3", 3'b100);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule